// File: doc/BRIEF.md
# Dual-Clock FIFO Pointer Crossing and Status Unit

This block is the control half of a dual-clock FIFO: the storage array sits elsewhere. It keeps a binary write position in the write clock domain and a binary read position in the read clock domain. Each position is one bit wider than the address. Before a position crosses to the other domain, it is turned into Gray code. A register chain then carries it across, and the chain length comes from a two-bit depth code. On arrival the value is turned back into binary. From these values the block produces full and almost-full in the write domain and empty and almost-empty in the read domain.

Two further choices are set by parameters. The first picks the reset source of the write-side logic: the local write reset, the read reset carried across by its own depth-coded chain, or both together. The second picks the clock domain in which each position counter is reported. A single-clock mode drops every crossing chain and builds the flags straight from the two positions. Thresholds, widths and all modes are parameters, and the parent FIFO uses the flags to gate its memory ports.

Top module: `dcx_ptr_xing`

## Requirements
- R1: A depth code of 2'b00, 2'b01, 2'b10 or 2'b11 gives 2, 3, 4 or 5 synchronizer stages. A position change made at clock edge k reaches the other domain's flags and counters after edge k+stages of that domain's clock.
- R2: Each position crosses as Gray code, so the value entering a chain changes by at most one bit per source clock. Empty is asserted exactly when the read position equals the write position seen in the read domain.
- R3: full is 1 exactly when the write position minus the read position seen in the write domain (modulo 2·DEPTH) equals DEPTH. Internally this is the Gray compare with the two top bits of the crossed read value inverted.
- R4: empty is 1 exactly when the write position seen in the read domain equals the read position.
- R5: almost_full is 1 when the write-domain occupancy is at or above AF_LEVEL. It is always 1 while full is 1.
- R6: almost_empty is 1 when the read-domain occupancy is at or below AE_LEVEL. It is always 1 while empty is 1.
- R7: wr_count is the number of accepted writes modulo 2·DEPTH. With WRCNT_IN_WR=1 it is the write-domain register. With WRCNT_IN_WR=0 it is the value carried into the read domain.
- R8: rd_count is the number of accepted reads modulo 2·DEPTH. With RDCNT_IN_RD=1 it is the read-domain register. With RDCNT_IN_RD=0 it is the value carried into the write domain.
- R9: A write request while full and a read request while empty leave the positions unchanged.
- R10: While reset is held, full=0, almost_full=0, empty=1, almost_empty=1 and both counts are 0. Resets assert asynchronously and release synchronously.
- R11: WRST_MODE selects the write-side reset. Codes 2'b00 and 2'b01 use wr_rst_n. Code 2'b10 uses rd_rst_n carried into the write domain through a chain of RDRST_SYNC_CODE depth. Code 2'b11 uses either of them.
- R12: With SYNC_MODE=1 no chains are used. The flags and counts follow the positions in the cycle right after the edge that moved them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-side reset, active low |
| wr_en | input | 1 | Write request |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-side reset, active low |
| rd_en | input | 1 | Read request |
| full | output | 1 | No free entry (write domain) |
| almost_full | output | 1 | Occupancy at or above AF_LEVEL (write domain) |
| empty | output | 1 | No stored entry (read domain) |
| almost_empty | output | 1 | Occupancy at or below AE_LEVEL (read domain) |
| wr_count | output | ADDR_W+1 | Accepted-write count, domain chosen by WRCNT_IN_WR |
| rd_count | output | ADDR_W+1 | Accepted-read count, domain chosen by RDCNT_IN_RD |

## Verification
A request sampled at edge c moves its own position and the flags of its own domain right after edge c. In the other domain the flags and the reported count move only after edge c plus that chain's stage count: two stages for the read position and four for the write position in the main instance. A cycle-exact reference model keeps the history of both positions. For each driven edge it pushes the expected flags and counts, indexed by the delayed history entries, into a queue tagged with that edge. A monitor on the falling edge pops the entry whose edge has just passed, so every comparison lands in the first cycle where the result is due. Reset, the read-only reset path and the single-clock instance are sampled after enough idle cycles for every chain to settle.

// File: rtl/dcx_pkg.sv
package dcx_pkg;

  // Stage count selected by a two-bit synchronizer depth code.
  function automatic int unsigned sync_len(input logic [1:0] code);
    return int'(code) + 2;
  endfunction

  // Write-side reset source selection.
  typedef enum logic [1:0] {
    WRST_LOCAL   = 2'b00,
    WRST_LOCAL_B = 2'b01,
    WRST_REMOTE  = 2'b10,
    WRST_EITHER  = 2'b11
  } wrst_sel_e;

endpackage

// File: rtl/dcx_sync_chain.sv
module dcx_sync_chain #(
  parameter int unsigned W    = 1,
  parameter logic [1:0]  CODE = 2'b00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int unsigned N = dcx_pkg::sync_len(CODE);

  logic [N-1:0][W-1:0] stg_q;
  logic [N-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[N-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[N-1];
endmodule

// File: rtl/dcx_ptr_ctr.sv
module dcx_ptr_ctr #(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          blocked,
  output logic [PW-1:0] bin_o,
  output logic [PW-1:0] gray_o
);
  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic          step;

  always_comb begin
    step   = req & ~blocked;
    bin_d  = bin_q + PW'(1);
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (step) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign bin_o  = bin_q;
  assign gray_o = gray_q;

  // R9: a refused request leaves the position alone
  assert_hold_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && blocked) |=> $stable(bin_q));

  // R2: the value fed to a crossing changes by at most one bit
  assert_gray_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/dcx_ptr_xing.sv
module dcx_ptr_xing #(
  parameter int unsigned ADDR_W          = 3,
  parameter logic [1:0]  RPTR_SYNC_CODE  = 2'b00,
  parameter logic [1:0]  WPTR_SYNC_CODE  = 2'b00,
  parameter logic [1:0]  RDRST_SYNC_CODE = 2'b00,
  parameter logic [1:0]  WRST_MODE       = 2'b00,
  parameter bit          SYNC_MODE       = 1'b0,
  parameter bit          WRCNT_IN_WR     = 1'b1,
  parameter bit          RDCNT_IN_RD     = 1'b1,
  parameter int unsigned AF_LEVEL        = 6,
  parameter int unsigned AE_LEVEL        = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic              full,
  output logic              almost_full,
  output logic              empty,
  output logic              almost_empty,
  output logic [ADDR_W:0]   wr_count,
  output logic [ADDR_W:0]   rd_count
);
  import dcx_pkg::*;

  localparam int unsigned PW        = ADDR_W + 1;
  localparam int unsigned DEPTH     = 1 << ADDR_W;
  localparam logic [PW-1:0] FULL_MASK = PW'(3) << (PW - 2);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- reset generation ----------------
  logic wr_loc_rst_n, rd_in_wr_rst_n, wptr_rst_n, rd_dom_rst_n;

  dcx_sync_chain #(.W(1), .CODE(2'b00)) u_wr_rst (
    .clk(wr_clk), .rst_n(wr_rst_n), .din(1'b1), .dout(wr_loc_rst_n));

  dcx_sync_chain #(.W(1), .CODE(RDRST_SYNC_CODE)) u_rd_rst_w (
    .clk(wr_clk), .rst_n(rd_rst_n), .din(1'b1), .dout(rd_in_wr_rst_n));

  dcx_sync_chain #(.W(1), .CODE(2'b00)) u_rd_rst (
    .clk(rd_clk), .rst_n(rd_rst_n), .din(1'b1), .dout(rd_dom_rst_n));

  always_comb begin
    case (wrst_sel_e'(WRST_MODE))
      WRST_REMOTE: wptr_rst_n = rd_in_wr_rst_n;
      WRST_EITHER: wptr_rst_n = rd_in_wr_rst_n & wr_loc_rst_n;
      default:     wptr_rst_n = wr_loc_rst_n;
    endcase
  end

  // ---------------- positions ----------------
  logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
  logic [PW-1:0] rg_w, wg_r;           // crossed Gray values
  logic [PW-1:0] rbin_w, wbin_r, occ_w, occ_r;

  dcx_ptr_ctr #(.PW(PW)) u_wptr (
    .clk(wr_clk), .rst_n(wptr_rst_n), .req(wr_en), .blocked(full),
    .bin_o(wr_bin), .gray_o(wr_gray));

  dcx_ptr_ctr #(.PW(PW)) u_rptr (
    .clk(rd_clk), .rst_n(rd_dom_rst_n), .req(rd_en), .blocked(empty),
    .bin_o(rd_bin), .gray_o(rd_gray));

  // ---------------- crossings ----------------
  generate
    if (SYNC_MODE) begin : g_bypass
      assign rg_w = rd_gray;
      assign wg_r = wr_gray;
    end else begin : g_cross
      dcx_sync_chain #(.W(PW), .CODE(RPTR_SYNC_CODE)) u_r2w (
        .clk(wr_clk), .rst_n(wptr_rst_n), .din(rd_gray), .dout(rg_w));
      dcx_sync_chain #(.W(PW), .CODE(WPTR_SYNC_CODE)) u_w2r (
        .clk(rd_clk), .rst_n(rd_dom_rst_n), .din(wr_gray), .dout(wg_r));
    end
  endgenerate

  // ---------------- status ----------------
  always_comb begin
    rbin_w       = g2b(rg_w);
    wbin_r       = g2b(wg_r);
    occ_w        = wr_bin - rbin_w;
    occ_r        = wbin_r - rd_bin;
    full         = (wr_gray == (rg_w ^ FULL_MASK));
    almost_full  = (occ_w >= PW'(AF_LEVEL));
    empty        = (rd_gray == wg_r);
    almost_empty = (occ_r <= PW'(AE_LEVEL));
    wr_count     = WRCNT_IN_WR ? wr_bin : wbin_r;
    rd_count     = RDCNT_IN_RD ? rd_bin : rbin_w;
  end

  // R5: full occupancy always meets the upper threshold
  assert_full_implies_af_R5: assert property (@(posedge wr_clk) disable iff (!wptr_rst_n)
    full |-> almost_full);

  // R6: zero occupancy always meets the lower threshold
  assert_empty_implies_ae_R6: assert property (@(posedge rd_clk) disable iff (!rd_dom_rst_n)
    empty |-> almost_empty);

  // R3: write-domain occupancy never exceeds the capacity
  assert_occ_bound_R3: assert property (@(posedge wr_clk) disable iff (!wptr_rst_n)
    occ_w <= PW'(DEPTH));

  initial begin
    assert_params_R5: assert (AF_LEVEL <= DEPTH && ADDR_W >= 1);
  end
endmodule

// File: tb/sim_dcx_ptr_xing.sv
`timescale 1ns/1ps
module sim_dcx_ptr_xing;
  localparam int NR = 2;   // read position -> write domain stages (code 00)
  localparam int NW = 4;   // write position -> read domain stages (code 10)
  localparam int AFL = 6;
  localparam int AEL = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;    // 250 MHz

  logic rst_n, rdp_n, wr_en, rd_en, s_wr, s_rd;
  logic f0, af0, e0, ae0, f1, af1, e1, ae1;
  logic [3:0] wc0, rc0, wc1, rc1;

  dcx_ptr_xing #(.ADDR_W(3), .RPTR_SYNC_CODE(2'b00), .WPTR_SYNC_CODE(2'b10),
    .RDRST_SYNC_CODE(2'b01), .WRST_MODE(2'b11), .SYNC_MODE(1'b0),
    .WRCNT_IN_WR(1'b0), .RDCNT_IN_RD(1'b1), .AF_LEVEL(AFL), .AE_LEVEL(AEL)) u0 (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en),
    .rd_clk(clk), .rd_rst_n(rst_n & rdp_n), .rd_en(rd_en),
    .full(f0), .almost_full(af0), .empty(e0), .almost_empty(ae0),
    .wr_count(wc0), .rd_count(rc0));

  dcx_ptr_xing #(.ADDR_W(3), .SYNC_MODE(1'b1), .AF_LEVEL(AFL), .AE_LEVEL(AEL)) u1 (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(s_wr),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(s_rd),
    .full(f1), .almost_full(af1), .empty(e1), .almost_empty(ae1),
    .wr_count(wc1), .rd_count(rc1));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  logic [3:0] wh[4096];
  logic [3:0] rh[4096];
  int base = 0;

  function automatic logic [3:0] W(int i);
    if (i <= base) return 4'd0;
    return wh[i];
  endfunction
  function automatic logic [3:0] R(int i);
    if (i <= base) return 4'd0;
    return rh[i];
  endfunction

  typedef struct {
    int due;
    logic f, af, e, ae;
    logic [3:0] wc, rc;
  } exp_t;
  exp_t sb[$];

  // driver: applies one request pair and queues what is due after that edge
  task automatic drive(input bit w, input bit r);
    int c;
    logic [3:0] occw, occr;
    bit fullp, emptyp;
    exp_t x;
    @(negedge clk); #1;
    wr_en = w; rd_en = r;
    c = cyc + 1;
    fullp  = ((W(c-1) - R(c-1-NR)) == 4'd8);
    emptyp = (W(c-1-NW) == R(c-1));
    wh[c] = W(c-1) + ((w && !fullp) ? 4'd1 : 4'd0);    // R9
    rh[c] = R(c-1) + ((r && !emptyp) ? 4'd1 : 4'd0);
    occw = W(c) - R(c-NR);
    occr = W(c-NW) - R(c);
    x.due = c;
    x.f   = (occw == 4'd8);
    x.af  = (occw >= 4'(AFL));
    x.e   = (W(c-NW) == R(c));
    x.ae  = (occr <= 4'(AEL));
    x.wc  = W(c-NW);        // write count carried into read domain
    x.rc  = R(c);
    sb.push_back(x);
  endtask

  // monitor: compares in the first cycle a result is due (R1 latencies)
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t x;
      x = sb.pop_front();
      if (x.due != cyc) chk("R1 timing", 4'(cyc - x.due), 4'd0);
      chk("R3/R1 full",          {3'd0, f0},  {3'd0, x.f});
      chk("R5 almost_full",      {3'd0, af0}, {3'd0, x.af});
      chk("R4/R2 empty",         {3'd0, e0},  {3'd0, x.e});
      chk("R6 almost_empty",     {3'd0, ae0}, {3'd0, x.ae});
      chk("R7 wr_count",         wc0, x.wc);
      chk("R8 rd_count",         rc0, x.rc);
    end
  end

  task automatic u1op(input bit w, input bit r);
    @(negedge clk); #1;
    s_wr = w; s_rd = r;
    @(negedge clk); #1;
    s_wr = 1'b0; s_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rdp_n = 1'b1;
    wr_en = 1'b0; rd_en = 1'b0; s_wr = 1'b0; s_rd = 1'b0;
    repeat (3) @(negedge clk);
    // R10: held reset state
    chk("R10 full",  {3'd0, f0},  4'd0);
    chk("R10 afull", {3'd0, af0}, 4'd0);
    chk("R10 empty", {3'd0, e0},  4'd1);
    chk("R10 aempty",{3'd0, ae0}, 4'd1);
    chk("R10 wcnt",  wc0, 4'd0);
    chk("R10 rcnt",  rc0, 4'd0);
    chk("R10 empty sync", {3'd0, e1}, 4'd1);
    #1 rst_n = 1'b1;
    repeat (8) @(negedge clk);
    base = cyc;

    // fill past capacity, then drain past empty
    repeat (12) drive(1, 0);
    repeat (6)  drive(0, 0);
    chk("R9 writes while full ignored", wc0, 4'd8);
    repeat (12) drive(0, 1);
    repeat (6)  drive(0, 0);
    chk("R9 reads while empty ignored", rc0, 4'd8);

    // mixed traffic
    for (int i = 0; i < 60; i++)
      drive((i % 3) != 2, ((i % 4) == 1) || (i > 30 && (i % 2) == 0));
    for (int i = 0; i < 40; i++) drive((i % 5) < 3, (i % 2) == 1);
    while (W(cyc) == 4'd0) drive(1, 0);
    repeat (6) drive(0, 0);
    repeat (3) @(negedge clk);

    // R11: read-side reset alone clears the write position (mode 11)
    #1 rdp_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rdp_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R11 wr position cleared", wc0, 4'd0);
    chk("R11 empty after rd reset", {3'd0, e0}, 4'd1);
    chk("R11 full after rd reset",  {3'd0, f0}, 4'd0);
    chk("R11 rd position cleared",  rc0, 4'd0);
    base = cyc;
    for (int i = 0; i < 30; i++) drive((i % 4) != 3, (i % 3) == 0);
    repeat (8) drive(0, 0);
    repeat (3) @(negedge clk);

    // R12: single-clock instance, no crossing delay
    u1op(1, 0);
    chk("R12 empty drops next cycle", {3'd0, e1}, 4'd0);
    chk("R12 wr_count", wc1, 4'd1);
    chk("R6 almost_empty at 1", {3'd0, ae1}, 4'd1);
    repeat (7) u1op(1, 0);
    chk("R12 full after 8 writes", {3'd0, f1}, 4'd1);
    chk("R5 almost_full sync", {3'd0, af1}, 4'd1);
    u1op(1, 0);
    chk("R9 sync write while full", wc1, 4'd8);
    u1op(0, 1);
    chk("R12 full drops next cycle", {3'd0, f1}, 4'd0);
    chk("R8 rd_count sync", rc1, 4'd1);
    u1op(1, 1);
    chk("R7 wr_count both", wc1, 4'd9);
    chk("R8 rd_count both", rc1, 4'd2);

    finish_run();
  end
endmodule